// File: doc/BRIEF.md
# Pointer-Based Shift-Mode Lookup Table

This block is a 4-input lookup table with 16 one-bit entries. The same storage serves two purposes, chosen by a mode pin. In logic mode, the 4-bit input selects one entry and that bit drives the output combinationally. In shift mode, the table behaves as a 16-stage serial shift register.

The shift is not done by moving every bit. A circular pointer names one entry. Each accepted serial bit overwrites only that entry, and the pointer then steps forward by one, wrapping from 15 to 0. The output always shows the entry at the pointer, which is the bit accepted 16 shifts earlier. One address selector decodes either the logic input or the pointer, and both the read path and the single-entry write use it. A full 16-bit configuration word can be loaded in one cycle. A counter reports how many entry writes have taken place.

The serial input is a valid/ready stream. A bit is taken on a rising clock edge when `sin_valid` and `sin_ready` are both high. `sin_ready` is high only in shift mode while no configuration load is requested. A source may hold `sin_valid` high while `sin_ready` is low: nothing is written, and the bit waits for a later edge. `lut_out` is a plain level output. During a transfer it carries the bit that the transfer pushes out.

Top module: `ptr_shift_lut`

## Requirements
- R1: In logic mode (`shift_mode`=0), `lut_out` equals entry number `lut_in` in the same cycle. Entry i is bit i of the storage.
- R2: In shift mode, `lut_out` equals the entry at the pointer. After a load of word W, this is W[0], then W[1], and so on. After 16 or more accepted bits, it is the bit accepted 16 transfers earlier.
- R3: An accepted serial bit writes `sin_data` into the entry at the pointer only and advances the pointer by one modulo 16. The other 15 entries keep their values.
- R4: `sin_ready` is 1 exactly when `shift_mode`=1 and `cfg_load`=0. `sin_valid` with `sin_ready` low changes no entry, the pointer or the write count.
- R5: In logic mode the pointer holds its value. Lookups after shifting return entries in physical order, not rotated by the pointer.
- R6: `cfg_load`=1 writes bit i of `cfg_word` into entry i for all 16 entries and clears the pointer to 0, on the next edge, in either mode. It takes priority over a serial transfer.
- R7: `wr_count` rises by exactly 1 per accepted serial bit and by 16 per configuration load, and wraps modulo 2^CNT_W.
- R8: A synchronous reset (`rst`=1 at an edge) clears all entries, the pointer and `wr_count` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_mode | input | 1 | 0 = logic lookup, 1 = shift register |
| lut_in | input | 4 | Logic-mode entry address |
| sin_valid | input | 1 | Serial bit offered |
| sin_ready | output | 1 | Serial bit can be taken this cycle |
| sin_data | input | 1 | Serial input bit |
| cfg_load | input | 1 | Load all entries from `cfg_word` |
| cfg_word | input | 16 | Configuration word, bit i goes to entry i |
| lut_out | output | 1 | Looked-up bit or shift-out bit |
| wr_count | output | 16 | Total entry writes, wrapping |

## Verification
`lut_out` and `sin_ready` are combinational. The bench checks them at the falling edge in the same cycle as the inputs that select them. A transfer, load or reset takes effect at the next rising edge. The bench therefore checks `wr_count` one time unit after that edge, and checks the new pointer position through `lut_out` in the following cycle. A bench-side 16-deep shift-register model predicts the shift-out bit. A separate physical-order model predicts logic lookups, so that a pointer-rotated read would show up as a mismatch.

// File: rtl/ptr_lut_pkg.sv
package ptr_lut_pkg;
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_SINGLE = 2'd1,
    WR_BULK   = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/lut_sel.sv
module lut_sel #(
  parameter int SEL_W = 4,
  localparam int ENTRIES = 1 << SEL_W
) (
  input  logic               shift_mode,
  input  logic [SEL_W-1:0]   ptr,
  input  logic [SEL_W-1:0]   lut_in,
  input  logic [ENTRIES-1:0] store,
  output logic [ENTRIES-1:0] row,
  output logic               rd_bit
);
  logic [SEL_W-1:0] addr;

  always_comb addr = shift_mode ? ptr : lut_in;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_row
    assign row[i] = (addr == SEL_W'(i));
  end

  always_comb rd_bit = |(row & store);
endmodule

// File: rtl/lut_store.sv
module lut_store
  import ptr_lut_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int ENTRIES = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  wr_kind_e           kind,
  input  logic [ENTRIES-1:0] row,
  input  logic               din,
  input  logic [ENTRIES-1:0] cfg_word,
  output logic [ENTRIES-1:0] store
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        store[i] <= 1'b0;
      end else if (kind == WR_BULK) begin
        store[i] <= cfg_word[i];
      end else if (kind == WR_SINGLE && row[i]) begin
        store[i] <= din;
      end
    end
  end
endmodule

// File: rtl/lut_ptr.sv
module lut_ptr
  import ptr_lut_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_kind_e         kind,
  output logic [SEL_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (kind == WR_BULK) begin
      ptr <= '0;
    end else if (kind == WR_SINGLE) begin
      ptr <= ptr + SEL_W'(1);
    end
  end
endmodule

// File: rtl/lut_wcount.sv
module lut_wcount
  import ptr_lut_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int CNT_W = 16,
  localparam int ENTRIES = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_kind_e         kind,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] step;

  always_comb begin
    case (kind)
      WR_BULK:   step = CNT_W'(ENTRIES);
      WR_SINGLE: step = CNT_W'(1);
      default:   step = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + step;
  end
endmodule

// File: rtl/ptr_shift_lut.sv
module ptr_shift_lut
  import ptr_lut_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int CNT_W = 16,
  localparam int ENTRIES = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_mode,
  input  logic [SEL_W-1:0]   lut_in,
  input  logic               sin_valid,
  output logic               sin_ready,
  input  logic               sin_data,
  input  logic               cfg_load,
  input  logic [ENTRIES-1:0] cfg_word,
  output logic               lut_out,
  output logic [CNT_W-1:0]   wr_count
);
  wr_kind_e           kind;
  logic [SEL_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] store_q;
  logic [ENTRIES-1:0] row;

  always_comb sin_ready = shift_mode && !cfg_load;

  always_comb begin
    if (cfg_load)                   kind = WR_BULK;
    else if (sin_valid && sin_ready) kind = WR_SINGLE;
    else                            kind = WR_NONE;
  end

  lut_sel #(.SEL_W(SEL_W)) sel_i (
    .shift_mode (shift_mode),
    .ptr        (ptr_q),
    .lut_in     (lut_in),
    .store      (store_q),
    .row        (row),
    .rd_bit     (lut_out)
  );

  lut_store #(.SEL_W(SEL_W)) store_i (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .row      (row),
    .din      (sin_data),
    .cfg_word (cfg_word),
    .store    (store_q)
  );

  lut_ptr #(.SEL_W(SEL_W)) ptr_i (
    .clk  (clk),
    .rst  (rst),
    .kind (kind),
    .ptr  (ptr_q)
  );

  lut_wcount #(.SEL_W(SEL_W), .CNT_W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst   (rst),
    .kind  (kind),
    .count (wr_count)
  );
endmodule

// File: rtl/ptr_shift_lut_chk.sv
module ptr_shift_lut_chk #(
  parameter int SEL_W = 4,
  parameter int CNT_W = 16,
  localparam int ENTRIES = 1 << SEL_W
) (
  input logic               clk,
  input logic               rst,
  input logic               shift_mode,
  input logic               sin_valid,
  input logic               sin_ready,
  input logic               sin_data,
  input logic               cfg_load,
  input logic [CNT_W-1:0]   wr_count,
  input logic [SEL_W-1:0]   ptr,
  input logic [ENTRIES-1:0] store
);
  logic               take;
  logic [ENTRIES-1:0] wmask;

  always_comb take = sin_valid && sin_ready;
  always_comb wmask = {{(ENTRIES-1){1'b0}}, 1'b1} << ptr;

  AST_SHIFT_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    take && !cfg_load |=> wr_count == $past(wr_count) + CNT_W'(1)); // R7

  AST_LOAD_ALL_WRITES: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> wr_count == $past(wr_count) + CNT_W'(ENTRIES)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cfg_load && !take |=> $stable(wr_count) && $stable(ptr) && $stable(store)); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    take |=> ptr == $past(ptr) + SEL_W'(1)); // R3

  AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    take |=> ((store & ~$past(wmask)) == ($past(store) & ~$past(wmask)))
             && (store[$past(ptr)] == $past(sin_data))); // R3

  AST_LOAD_PTR_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> ptr == '0); // R6

  AST_NO_READY_LOGIC: assert property (@(posedge clk) disable iff (rst)
    !shift_mode |-> !sin_ready); // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> wr_count == '0 && ptr == '0 && store == '0); // R8
endmodule

bind ptr_shift_lut ptr_shift_lut_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .shift_mode (shift_mode),
  .sin_valid  (sin_valid),
  .sin_ready  (sin_ready),
  .sin_data   (sin_data),
  .cfg_load   (cfg_load),
  .wr_count   (wr_count),
  .ptr        (ptr_q),
  .store      (store_q)
);

// File: tb/ptr_shift_lut_tb_top.sv
module ptr_shift_lut_tb_top;
  localparam int CLK_P = 10;
  localparam int SEL_W = 4;
  localparam int CNT_W = 16;
  localparam int ENT   = 1 << SEL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             shift_mode = 1'b0;
  logic [SEL_W-1:0] lut_in = '0;
  logic             sin_valid = 1'b0;
  logic             sin_ready;
  logic             sin_data = 1'b0;
  logic             cfg_load = 1'b0;
  logic [ENT-1:0]   cfg_word = '0;
  logic             lut_out;
  logic [CNT_W-1:0] wr_count;

  int checks = 0;
  int errors = 0;

  // bench models
  logic [ENT-1:0]   sr_m  = '0;   // sr_m[0] is the oldest bit
  logic [ENT-1:0]   mem_m = '0;   // physical entries
  int               ptr_m = 0;
  logic [CNT_W-1:0] cnt_m = '0;

  always #(CLK_P/2) clk = ~clk;

  ptr_shift_lut #(.SEL_W(SEL_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .shift_mode(shift_mode), .lut_in(lut_in),
    .sin_valid(sin_valid), .sin_ready(sin_ready), .sin_data(sin_data),
    .cfg_load(cfg_load), .cfg_word(cfg_word), .lut_out(lut_out),
    .wr_count(wr_count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_ready(input logic m, input logic ld);
    return m && !ld;
  endfunction

  // One clock cycle: drive at posedge+1, check combinational outputs at the
  // falling edge, then check registered results one unit after the next edge.
  task automatic cyc(input logic r, input logic m, input logic [SEL_W-1:0] a,
                     input logic v, input logic d, input logic ld,
                     input logic [ENT-1:0] w, input string otag);
    logic acc;
    rst = r; shift_mode = m; lut_in = a; sin_valid = v; sin_data = d;
    cfg_load = ld; cfg_word = w;
    #(CLK_P/2 - 1);
    if (!r) begin
      chk(sin_ready == exp_ready(m, ld), "R4 ready", sin_ready, exp_ready(m, ld));
      if (m) chk(lut_out == sr_m[0], otag, lut_out, sr_m[0]);
      else   chk(lut_out == mem_m[a], otag, lut_out, mem_m[a]);
    end
    @(posedge clk);
    #1;
    acc = v && exp_ready(m, ld);
    if (r) begin
      sr_m = '0; mem_m = '0; ptr_m = 0; cnt_m = '0;
      chk(wr_count == cnt_m, "R8 count", wr_count, cnt_m);
    end else begin
      if (ld) begin
        sr_m = w; mem_m = w; ptr_m = 0; cnt_m = cnt_m + CNT_W'(ENT);
      end else if (acc) begin
        sr_m = {d, sr_m[ENT-1:1]};
        mem_m[ptr_m] = d;
        ptr_m = (ptr_m + 1) % ENT;
        cnt_m = cnt_m + CNT_W'(1);
      end
      chk(wr_count == cnt_m, "R7 count", wr_count, cnt_m);
    end
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < ENT; i++) cyc(1'b0, 1'b0, SEL_W'(i), 1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    // reset state (R8)
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R8");
    read_all("R8 entries after reset");
    cyc(1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, '0, "R8 shift out after reset");

    // configuration load and physical lookups (R6, R1)
    cyc(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 16'hA5C3, "R1");
    read_all("R6 loaded entry");
    read_all("R1 lookup");

    // offers in logic mode are refused (R4); pointer held (R5)
    for (int i = 0; i < 20; i++)
      cyc(1'b0, 1'b0, SEL_W'($urandom), 1'b1, 1'($urandom), 1'b0, '0, "R4 refused offer");
    cyc(1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, '0, "R5 pointer held at zero");

    // random shifting with gaps (R2, R3)
    for (int i = 0; i < 300; i++)
      cyc(1'b0, 1'b1, SEL_W'($urandom), 1'(($urandom % 10) < 7), 1'($urandom), 1'b0, '0, "R2 shift out");
    // force pointer off zero, then check physical order (R5, R3)
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, '0, 1'b1, 1'(i), 1'b0, '0, "R2 shift out");
    if (ptr_m == 0) cyc(1'b0, 1'b1, '0, 1'b1, 1'b1, 1'b0, '0, "R2 shift out");
    read_all("R5 physical order");
    read_all("R3 single entry write");
    cyc(1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, '0, "R5 pointer held after logic reads");

    // load beats a concurrent offer (R6)
    cyc(1'b0, 1'b1, '0, 1'b1, 1'b1, 1'b1, 16'h3C96, "R2");
    for (int i = 0; i < 16; i++) cyc(1'b0, 1'b1, '0, 1'b1, 1'($urandom), 1'b0, '0, "R6 load then shift");
    for (int i = 0; i < 16; i++) cyc(1'b0, 1'b1, '0, 1'b1, 1'($urandom), 1'b0, '0, "R2 bit from 16 ago");

    // mixed random traffic including loads and mode changes
    for (int i = 0; i < 500; i++) begin
      logic m = 1'($urandom);
      logic ld = 1'(($urandom % 25) == 0);
      cyc(1'b0, m, SEL_W'($urandom), 1'($urandom), 1'($urandom), ld, ENT'($urandom),
          m ? "R2 mixed" : "R1 mixed");
    end

    // count wrap: 4096 loads add 2^16 (R7)
    for (int i = 0; i < 4096; i++) cyc(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 16'h0F0F, "R1");
    chk(wr_count == cnt_m, "R7 wrap", wr_count, cnt_m);

    // reset mid-run (R8)
    cyc(1'b0, 1'b1, '0, 1'b1, 1'b1, 1'b0, '0, "R2");
    cyc(1'b1, 1'b1, '0, 1'b1, 1'b1, 1'b0, '0, "R8");
    read_all("R8 entries after second reset");
    cyc(1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, '0, "R8 pointer after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule